// File: doc/BRIEF.md
# Interrupt Vector Relocation Controller

This block holds an 8-bit interrupt-control register. The register decides where the interrupt vector table sits. The table sits either at word 0 of program memory or at the first word of a boot-loader region at the top of memory. The size of that region comes from a 2-bit boot-size code. The rest of the register stores five interrupt-enable bits for the interrupt logic around the block.

The select bit is guarded by a timed unlock. Software first writes the change-enable bit. It then writes the new select value, with change-enable cleared, inside a four-cycle window. While the unlock runs, the block raises a suppress output to the interrupt arbiter. That output holds off interrupt acceptance through the window and until one instruction retires after the select write. The processor's global interrupt flag is never touched, because suppression is a separate output.

Two lock inputs also hold off interrupts while code runs in the section that does not hold the vectors.

Top module: `ivec_reloc_ctrl`

## Requirements
- R1: After synchronous reset, the register reads 0x00, `irq_suppress` is 0 and `vec_base` is 0.
- R2: While the select bit (bit 1) is 0, `vec_base` is 0.
- R3: A write with bit 0 = 0 in any cycle of an open window copies write bit 1 into the select bit. It also closes the window, and the register reflects this from the next cycle.
- R4: Write bit 0 = 1 is the arm write. From the cycle after it, the change-enable bit (bit 0) reads 1 and `irq_suppress` is 1 for as long as the window stays open.
- R5: With no further write, the window lasts exactly four cycles after the arm write. In the fifth cycle, bit 0 reads 0 and suppression from the unlock has ended.
- R6: A write with bit 0 = 0 while no window is open leaves the select bit unchanged. This includes a write one cycle after the window has closed.
- R7: Bits 7..3 take the written value on every write. Reads return bits 7..3, 0 in bit 2, the select bit in bit 1 and change-enable in bit 0.
- R8: After a select write, `irq_suppress` stays 1 up to and including the first cycle in which `instr_retire` is 1. It drops in the following cycle.
- R9: An arm write while a window is already open restarts the window at a full four cycles.
- R10: While the select bit is 1, `vec_base` equals MEM_WORDS minus (BOOT_MIN_WORDS << `boot_size_code`). With the defaults, codes 0, 1, 2 and 3 give 0x1F00, 0x1E00, 0x1C00 and 0x1800.
- R11: Lock gating is combinational. With select = 1, `lock_app` = 1 and `pc_in_boot` = 0, `irq_suppress` is 1. With select = 0, `lock_boot` = 1 and `pc_in_boot` = 1, it is also 1. Other lock and region combinations add no suppression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| instr_retire | input | 1 | One-cycle pulse per completed instruction |
| pc_in_boot | input | 1 | 1 when the program counter is in the boot region |
| boot_size_code | input | 2 | Boot region size code |
| lock_app | input | 1 | Application-side lock programmed |
| lock_boot | input | 1 | Boot-side lock programmed |
| vec_base | output | 13 | Vector table base word address |
| irq_suppress | output | 1 | Interrupt acceptance hold-off to the arbiter |

## Verification
Register contents, the change-enable window and the unlock-driven part of `irq_suppress` move one clock edge after the write or retire that causes them. `vec_base` and the lock gating follow their inputs within the same cycle. Inputs are driven just after a rising edge. For every cycle, the driver queues the values it expects at the next falling edge, where the monitor samples and compares them. A register effect is therefore checked in the cycle after its write, and a combinational effect in the cycle its inputs change. The window boundaries are checked cycle by cycle, including the fourth-cycle write and the cycle just after the window closes.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    localparam int REG_W    = 8;
    localparam int EN_W     = 5;
    localparam int CEN_BIT  = 0;
    localparam int VSEL_BIT = 1;
    localparam int EN_LSB   = 3;
    localparam int CODE_W   = 2;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef struct packed {
        logic [EN_W-1:0] irq_en;
        logic            vsel;
        logic            cen;
    } ivec_state_t;

    typedef enum logic [1:0] {
        UL_IDLE   = 2'd0,
        UL_ARMED  = 2'd1,
        UL_SETTLE = 2'd2
    } unlock_e;

    // Read image: bit 2 is reserved and always returns 0
    function automatic logic [REG_W-1:0] pack_rd(input ivec_state_t s);
        return {s.irq_en, 1'b0, s.vsel, s.cen};
    endfunction

    function automatic int boot_words(input int min_words, input int code);
        return min_words << code;
    endfunction
endpackage

// File: rtl/ivec_ctrl_reg.sv
module ivec_ctrl_reg
    import ivec_pkg::*;
#(
    parameter int WINDOW_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             retire,
    output ivec_state_t      st,
    output logic             settle
);
    localparam int CNT_W = $clog2(WINDOW_CYC + 1);

    unlock_e          ul_q, ul_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             vsel_q, vsel_d;
    logic [EN_W-1:0]  en_q, en_d;
    logic             arm_req, sel_req;

    assign arm_req = wr_en && wr_data[CEN_BIT];
    assign sel_req = wr_en && !wr_data[CEN_BIT] && (ul_q == UL_ARMED);

    always_comb begin
        ul_d   = ul_q;
        cnt_d  = cnt_q;
        vsel_d = vsel_q;
        en_d   = en_q;
        if (wr_en) begin
            en_d = wr_data[REG_W-1:EN_LSB];
        end
        if (arm_req) begin
            ul_d  = UL_ARMED;
            cnt_d = CNT_W'(WINDOW_CYC);
        end else if (sel_req) begin
            ul_d   = UL_SETTLE;
            vsel_d = wr_data[VSEL_BIT];
            cnt_d  = '0;
        end else begin
            case (ul_q)
                UL_ARMED: begin
                    if (cnt_q <= CNT_W'(1)) begin
                        ul_d  = UL_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                UL_SETTLE: begin
                    if (retire) begin
                        ul_d = UL_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ul_q   <= UL_IDLE;
            cnt_q  <= '0;
            vsel_q <= 1'b0;
            en_q   <= '0;
        end else begin
            ul_q   <= ul_d;
            cnt_q  <= cnt_d;
            vsel_q <= vsel_d;
            en_q   <= en_d;
        end
    end

    assign st.irq_en = en_q;
    assign st.vsel   = vsel_q;
    assign st.cen    = (ul_q == UL_ARMED);
    assign settle    = (ul_q == UL_SETTLE);

    // R3 R6
    vsel_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (vsel_q != $past(vsel_q)) |->
            $past(ul_q == UL_ARMED && wr_en && !wr_data[CEN_BIT]));

    // R5
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ul_q == UL_ARMED) |-> (cnt_q != '0 && cnt_q <= CNT_W'(WINDOW_CYC)));

    // R9
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[CEN_BIT]) |=> (st.cen && cnt_q == CNT_W'(WINDOW_CYC)));

    // R8
    settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (settle && !retire && !wr_en) |=> settle);
endmodule

// File: rtl/ivec_base_gen.sv
module ivec_base_gen
    import ivec_pkg::*;
#(
    parameter int MEM_WORDS      = 8192,
    parameter int BOOT_MIN_WORDS = 256,
    parameter int ADDR_W         = $clog2(MEM_WORDS)
) (
    input  logic              vsel,
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] base
);
    logic [ADDR_W-1:0] base_tbl [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_base
        localparam int BW = boot_words(BOOT_MIN_WORDS, g);
        assign base_tbl[g] = ADDR_W'(MEM_WORDS - BW);
    end

    assign base = vsel ? base_tbl[code] : '0;
endmodule

// File: rtl/ivec_irq_gate.sv
module ivec_irq_gate (
    input  logic armed,
    input  logic settle,
    input  logic vsel,
    input  logic pc_in_boot,
    input  logic lock_app,
    input  logic lock_boot,
    output logic suppress
);
    logic lock_hit;

    always_comb begin
        if (vsel) begin
            lock_hit = lock_app && !pc_in_boot;
        end else begin
            lock_hit = lock_boot && pc_in_boot;
        end
        suppress = armed || settle || lock_hit;
    end
endmodule

// File: rtl/ivec_reloc_ctrl.sv
module ivec_reloc_ctrl
    import ivec_pkg::*;
#(
    parameter int MEM_WORDS      = 8192,
    parameter int BOOT_MIN_WORDS = 256,
    parameter int WINDOW_CYC     = 4,
    parameter int ADDR_W         = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              instr_retire,
    input  logic              pc_in_boot,
    input  logic [CODE_W-1:0] boot_size_code,
    input  logic              lock_app,
    input  logic              lock_boot,
    output logic [ADDR_W-1:0] vec_base,
    output logic              irq_suppress
);
    ivec_state_t st;
    logic        settle;

    ivec_ctrl_reg #(.WINDOW_CYC(WINDOW_CYC)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we),
        .wr_data (reg_wdata),
        .retire  (instr_retire),
        .st      (st),
        .settle  (settle)
    );

    ivec_base_gen #(
        .MEM_WORDS      (MEM_WORDS),
        .BOOT_MIN_WORDS (BOOT_MIN_WORDS),
        .ADDR_W         (ADDR_W)
    ) u_base (
        .vsel (st.vsel),
        .code (boot_size_code),
        .base (vec_base)
    );

    ivec_irq_gate u_gate (
        .armed      (st.cen),
        .settle     (settle),
        .vsel       (st.vsel),
        .pc_in_boot (pc_in_boot),
        .lock_app   (lock_app),
        .lock_boot  (lock_boot),
        .suppress   (irq_suppress)
    );

    assign reg_rdata = pack_rd(st);

    // R4
    armed_sup_chk: assert property (@(posedge clk) disable iff (rst)
        st.cen |-> irq_suppress);

    // R8
    settle_sup_chk: assert property (@(posedge clk) disable iff (rst)
        settle |-> irq_suppress);

    // R2
    base_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[VSEL_BIT] |-> (vec_base == '0));

    // R10
    base_sum_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[VSEL_BIT] |->
            (int'(vec_base) + boot_words(BOOT_MIN_WORDS, int'(boot_size_code))) == MEM_WORDS);

    // R11
    lock_app_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[VSEL_BIT] && lock_app && !pc_in_boot) |-> irq_suppress);

    // R11
    lock_boot_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[VSEL_BIT] && lock_boot && pc_in_boot) |-> irq_suppress);
endmodule

// File: tb/tb_ivec_reloc_ctrl.sv
`timescale 1ns/1ps
module tb_ivec_reloc_ctrl;
    typedef struct {
        string       tag;
        logic [7:0]  rd;
        logic        sup;
        logic [12:0] base;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        instr_retire = 1'b0;
    logic        pc_in_boot = 1'b0;
    logic [1:0]  boot_size_code = 2'd2;
    logic        lock_app = 1'b0;
    logic        lock_boot = 1'b0;
    logic [12:0] vec_base;
    logic        irq_suppress;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    int   cyc    = 0;
    bit   done   = 0;

    always #4 clk = ~clk;

    ivec_reloc_ctrl dut (
        .clk            (clk),
        .rst            (rst),
        .reg_we         (reg_we),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .instr_retire   (instr_retire),
        .pc_in_boot     (pc_in_boot),
        .boot_size_code (boot_size_code),
        .lock_app       (lock_app),
        .lock_boot      (lock_boot),
        .vec_base       (vec_base),
        .irq_suppress   (irq_suppress)
    );

    task automatic step(input logic we, input logic [7:0] wd, input logic ret);
        @(posedge clk);
        #1;
        reg_we       = we;
        reg_wdata    = wd;
        instr_retire = ret;
    endtask

    task automatic expect_now(input string tag, input logic [7:0] rd,
                              input logic sup, input logic [12:0] base);
        exp_t e;
        e.tag = tag; e.rd = rd; e.sup = sup; e.base = base;
        exp_q.push_back(e);
    endtask

    // Monitor: compares at the falling edge, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (reg_rdata !== e.rd || irq_suppress !== e.sup || vec_base !== e.base) begin
                    n_fail++;
                    $display("FAIL %s: rd=%h sup=%b base=%h, expected rd=%h sup=%b base=%h",
                             e.tag, reg_rdata, irq_suppress, vec_base, e.rd, e.sup, e.base);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d, expected below 5000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        step(0, 8'h00, 0); rst = 1'b0;
        // R1 reset state
        step(0, 8'h00, 0); expect_now("R1", 8'h00, 0, 13'h0000);

        // R6 R7: unarmed write, select bit ignored, enables stored
        step(1, 8'hFA, 0); expect_now("R1", 8'h00, 0, 13'h0000);
        step(0, 8'h00, 0); expect_now("R6", 8'hF8, 0, 13'h0000);
        // R7 bit 2 reads 0
        step(1, 8'h04, 0);
        step(0, 8'h00, 0); expect_now("R7", 8'h00, 0, 13'h0000);

        // R4 R3 R8: full unlock to boot section
        step(1, 8'h01, 0);
        step(0, 8'h00, 0); expect_now("R4", 8'h01, 1, 13'h0000);
        step(1, 8'h02, 0); expect_now("R4", 8'h01, 1, 13'h0000);
        step(0, 8'h00, 0); expect_now("R3", 8'h02, 1, 13'h1C00);
        step(0, 8'h00, 0); expect_now("R8", 8'h02, 1, 13'h1C00);
        step(0, 8'h00, 1); expect_now("R8", 8'h02, 1, 13'h1C00);
        step(0, 8'h00, 0); expect_now("R8", 8'h02, 0, 13'h1C00);

        // R5: window expiry, then a late write is ignored
        step(1, 8'h01, 0);
        for (int i = 0; i < 4; i++) begin
            step(0, 8'h00, 0); expect_now("R5", 8'h03, 1, 13'h1C00);
        end
        step(1, 8'h00, 0); expect_now("R5", 8'h02, 0, 13'h1C00);
        step(0, 8'h00, 0); expect_now("R6", 8'h02, 0, 13'h1C00);

        // R3 boundary: write in fourth window cycle accepted
        step(1, 8'h01, 0);
        for (int i = 0; i < 3; i++) begin
            step(0, 8'h00, 0); expect_now("R3", 8'h03, 1, 13'h1C00);
        end
        step(1, 8'h00, 0); expect_now("R3", 8'h03, 1, 13'h1C00);
        step(0, 8'h00, 0); expect_now("R3", 8'h00, 1, 13'h0000);
        step(0, 8'h00, 1); expect_now("R8", 8'h00, 1, 13'h0000);
        step(0, 8'h00, 0); expect_now("R8", 8'h00, 0, 13'h0000);

        // R9: re-arm in third cycle restarts the window
        step(1, 8'h01, 0);
        step(0, 8'h00, 0); expect_now("R9", 8'h01, 1, 13'h0000);
        step(0, 8'h00, 0); expect_now("R9", 8'h01, 1, 13'h0000);
        step(1, 8'h01, 0); expect_now("R9", 8'h01, 1, 13'h0000);
        for (int i = 0; i < 4; i++) begin
            step(0, 8'h00, 0); expect_now("R9", 8'h01, 1, 13'h0000);
        end
        step(0, 8'h00, 0); expect_now("R9", 8'h00, 0, 13'h0000);

        // R10: relocate, then sweep boot size codes
        step(1, 8'h01, 0);
        step(1, 8'h02, 0);
        step(0, 8'h00, 1);
        step(0, 8'h00, 0); boot_size_code = 2'd0; expect_now("R10", 8'h02, 0, 13'h1F00);
        step(0, 8'h00, 0); boot_size_code = 2'd1; expect_now("R10", 8'h02, 0, 13'h1E00);
        step(0, 8'h00, 0); boot_size_code = 2'd2; expect_now("R10", 8'h02, 0, 13'h1C00);
        step(0, 8'h00, 0); boot_size_code = 2'd3; expect_now("R10", 8'h02, 0, 13'h1800);

        // R11: lock gating with vectors in the boot section
        step(0, 8'h00, 0); boot_size_code = 2'd2; lock_app = 1; pc_in_boot = 0;
        expect_now("R11", 8'h02, 1, 13'h1C00);
        step(0, 8'h00, 0); pc_in_boot = 1; expect_now("R11", 8'h02, 0, 13'h1C00);
        step(0, 8'h00, 0); lock_app = 0; lock_boot = 1; expect_now("R11", 8'h02, 0, 13'h1C00);
        // back to the application section
        step(0, 8'h00, 0); lock_boot = 0; pc_in_boot = 0;
        step(1, 8'h01, 0);
        step(1, 8'h00, 0);
        step(0, 8'h00, 1);
        step(0, 8'h00, 0); lock_boot = 1; pc_in_boot = 1; expect_now("R11", 8'h00, 1, 13'h0000);
        step(0, 8'h00, 0); pc_in_boot = 0; expect_now("R11", 8'h00, 0, 13'h0000);
        step(0, 8'h00, 0); lock_app = 1; expect_now("R2", 8'h00, 0, 13'h0000);

        step(0, 8'h00, 0);
        @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule